// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block records when something happened on an external pin. A free-running real-time counter, which lives outside the block, supplies its 32-bit low time slice. When the selected edge arrives on the asynchronous capture pin and the channel is armed, the block stores the low 21 bits of that slice. It then emits a one-cycle event pulse and sets a sticky pending flag.

Software controls the channel through single-cycle strobes. One strobe arms the channel and another disarms it. A level input selects rising or falling edges. Three more strobes set the pending flag, clear it, and report that the captured value was read. A read also clears the pending flag. Once armed, the channel stays armed and each later qualifying edge overwrites the stored value. Interrupt masking, the counter and register decoding belong to the surrounding logic.

Top module: `tscap_channel`

## Requirements
- R1: With `edgeFall` = 0 a low-to-high transition of the synchronized pin qualifies; with `edgeFall` = 1 a high-to-low transition qualifies; the other direction never captures.
- R2: A high `armSet` strobe sets `armed` on the next clock; a low strobe, or a strobe while already armed, leaves `armed` unchanged; after reset `armed` is 0.
- R3: A qualifying edge while `armed` is 0 changes neither `capValue`, `capEvent` nor `pending`.
- R4: A capture stores `timeLow[20:0]` into `capValue[20:0]`; `capValue[31:21]` always reads 0.
- R5: On a capture, `capEvent` is high for exactly one cycle, and in that same cycle `capValue` holds the new value and `pending` is 1.
- R6: A `swClr` or `capRead` strobe clears `pending` on the next clock when no capture or set coincides.
- R7: A `disarm` strobe clears `armed` on the next clock and wins over a simultaneous `armSet`; if a capture falls in the same cycle, the capture, event and flag still happen.
- R8: A `swSet` strobe sets `pending` on the next clock without an event pulse and without touching `capValue`.
- R9: A pin change made between clock edges shows up on `capEvent` after the third rising edge: two edges for the synchronizer and one for the capture register.
- R10: The channel stays armed after a capture, and each later qualifying edge overwrites `capValue`.
- R11: A capture in the same cycle as `swClr` or `capRead` leaves `pending` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| capPin | input | 1 | Asynchronous capture pin |
| timeLow | input | 32 | Low time slice of the real-time counter |
| armSet | input | 1 | Arm strobe |
| disarm | input | 1 | Disarm strobe |
| edgeFall | input | 1 | Edge select: 0 rising, 1 falling |
| capRead | input | 1 | Strobe: captured value was read |
| swSet | input | 1 | Software set of pending flag |
| swClr | input | 1 | Software clear of pending flag |
| capValue | output | 32 | Captured time, upper 11 bits zero |
| armed | output | 1 | Channel armed status |
| capEvent | output | 1 | One-cycle capture event pulse |
| pending | output | 1 | Sticky capture status flag |

## Verification
The hardest conditions to reach are the coincidences, because the qualifying edge only exists inside the block, two clocks after the pin moves. These are a disarm or a flag clear landing in exactly the cycle the capture fires. The stimulus changes the pin, counts two clock edges so that the synchronized edge is pending, and only then raises `disarm`, `swClr` or `capRead` for the single following edge. It then checks that the event, value and flag still appear.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
  // strobes from the control path into the storage path
  typedef struct packed {
    logic load;     // latch the time slice
    logic setFlag;  // raise the pending flag
    logic clrFlag;  // drop the pending flag (loses to setFlag)
  } capStrobe_t;
endpackage

// File: rtl/tscap_edge.sv
module tscap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseHit,
  output logic fallHit
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic lvl;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign lvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= lvl;
  end

  assign riseHit = lvl & ~prevQ;
  assign fallHit = ~lvl & prevQ;
endmodule

// File: rtl/tscap_ctrl.sv
module tscap_ctrl
  import tscap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       riseHit,
  input  logic       fallHit,
  input  logic       edgeFall,
  input  logic       armSet,
  input  logic       disarm,
  input  logic       capRead,
  input  logic       swSet,
  input  logic       swClr,
  output logic       armed,
  output logic       capEvent,
  output capStrobe_t strb
);
  logic armedQ;
  logic eventQ;
  logic hit;

  assign hit = armedQ & (edgeFall ? fallHit : riseHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armedQ <= 1'b0;
    else if (disarm) armedQ <= 1'b0;
    else if (armSet) armedQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eventQ <= 1'b0;
    else       eventQ <= hit;
  end

  always_comb begin
    strb.load    = hit;
    strb.setFlag = hit | swSet;
    strb.clrFlag = swClr | capRead;
  end

  assign armed    = armedQ;
  assign capEvent = eventQ;

  // R2
  arm_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armSet && !disarm) |=> armed);
  // R7
  disarm_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    disarm |=> !armed);
  // R3
  evt_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |-> $past(armed));
endmodule

// File: rtl/tscap_store.sv
module tscap_store
  import tscap_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int KEEP_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strb,
  input  logic [KEEP_W-1:0] timeSlice,
  output logic [TIME_W-1:0] capValue,
  output logic              flag
);
  localparam int PAD_W = TIME_W - KEEP_W;

  logic [KEEP_W-1:0] capQ;
  logic              flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          capQ <= '0;
    else if (strb.load) capQ <= timeSlice;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.setFlag) flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;
  end

  assign capValue = {{PAD_W{1'b0}}, capQ};
  assign flag     = flagQ;

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.setFlag) |=> !flag);
  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFlag |=> flag);
endmodule

// File: rtl/tscap_channel.sv
module tscap_channel
  import tscap_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int KEEP_W      = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capPin,
  input  logic [TIME_W-1:0] timeLow,
  input  logic              armSet,
  input  logic              disarm,
  input  logic              edgeFall,
  input  logic              capRead,
  input  logic              swSet,
  input  logic              swClr,
  output logic [TIME_W-1:0] capValue,
  output logic              armed,
  output logic              capEvent,
  output logic              pending
);
  logic       riseHit;
  logic       fallHit;
  capStrobe_t strb;
  logic       unusedTimeHi;

  assign unusedTimeHi = ^timeLow[TIME_W-1:KEEP_W];

  tscap_edge #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .pinIn(capPin),
    .riseHit(riseHit), .fallHit(fallHit)
  );

  tscap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .riseHit(riseHit), .fallHit(fallHit),
    .edgeFall(edgeFall), .armSet(armSet), .disarm(disarm),
    .capRead(capRead), .swSet(swSet), .swClr(swClr),
    .armed(armed), .capEvent(capEvent), .strb(strb)
  );

  tscap_store #(.TIME_W(TIME_W), .KEEP_W(KEEP_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb),
    .timeSlice(timeLow[KEEP_W-1:0]),
    .capValue(capValue), .flag(pending)
  );

  // R4
  cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |-> (capValue == {{(TIME_W-KEEP_W){1'b0}}, $past(timeLow[KEEP_W-1:0])}));
  // R5
  evt_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |-> pending);
endmodule

// File: tb/tscap_channel_test.sv
module tscap_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic [31:0] timeLow = '0;
  logic        armSet = 1'b0, disarm = 1'b0, edgeFall = 1'b0;
  logic        capRead = 1'b0, swSet = 1'b0, swClr = 1'b0;
  logic [31:0] capValue;
  logic        armed, capEvent, pending;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tscap_channel uut (
    .clk(clk), .rstN(rstN), .capPin(capPin), .timeLow(timeLow),
    .armSet(armSet), .disarm(disarm), .edgeFall(edgeFall),
    .capRead(capRead), .swSet(swSet), .swClr(swClr),
    .capValue(capValue), .armed(armed), .capEvent(capEvent), .pending(pending)
  );

  // {doArm, fallSel, newPin, time}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 32'h0000_0123},
    {1'b1, 1'b0, 1'b0, 32'h0000_0456},
    {1'b1, 1'b1, 1'b1, 32'h0000_0789},
    {1'b1, 1'b1, 1'b0, 32'h0001_ABCD},
    {1'b0, 1'b0, 1'b1, 32'h0000_0AAA},
    {1'b0, 1'b1, 1'b0, 32'h0000_0BBB},
    {1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 1'b0, 32'hABC1_2345}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic        pinNow;
    logic [31:0] expVal;
    pinNow = 1'b0;
    expVal = '0;
    step(); step();
    rstN = 1'b1;
    step();
    // reset state
    check("R2 reset armed", {31'b0, armed}, 32'd0);
    check("R5 reset event", {31'b0, capEvent}, 32'd0);
    check("R5 reset pending", {31'b0, pending}, 32'd0);
    check("R4 reset value", capValue, 32'd0);

    // vector table: R1 R3 R4 R10
    for (int i = 0; i < 8; i++) begin
      automatic logic [34:0] v = VEC[i];
      automatic logic expCap;
      expCap = v[34] && (v[32] != pinNow) && (v[33] ? !v[32] : v[32]);
      if (v[34]) armSet = 1'b1; else disarm = 1'b1;
      swClr = 1'b1;
      step();
      armSet = 1'b0; disarm = 1'b0; swClr = 1'b0;
      edgeFall = v[33];
      timeLow  = v[31:0];
      capPin   = v[32];
      step(); step(); step();
      if (expCap) expVal = v[31:0] & 32'h001F_FFFF;
      check("R1/R3 event", {31'b0, capEvent}, {31'b0, expCap});
      check("R4/R10 value", capValue, expVal);
      check("R5 pending", {31'b0, pending}, {31'b0, expCap});
      check("R2 armed", {31'b0, armed}, {31'b0, v[34]});
      step();
      check("R5 pulse width", {31'b0, capEvent}, 32'd0);
      pinNow = v[32];
    end

    // R9 latency, R10 stays armed (channel armed, pin low)
    armSet = 1'b1; step(); armSet = 1'b0;
    check("R2 rearm while armed", {31'b0, armed}, 32'd1);
    edgeFall = 1'b0; timeLow = 32'h0000_5555; capPin = 1'b1;
    step(); check("R9 edge1", {31'b0, capEvent}, 32'd0);
    step(); check("R9 edge2", {31'b0, capEvent}, 32'd0);
    step(); check("R9 edge3", {31'b0, capEvent}, 32'd1);
    check("R9 value", capValue, 32'h0000_5555);
    step(); check("R10 still armed", {31'b0, armed}, 32'd1);

    // R6 read clears, R8 set without event
    capRead = 1'b1; step(); capRead = 1'b0;
    check("R6 read clears", {31'b0, pending}, 32'd0);
    swSet = 1'b1; step(); swSet = 1'b0;
    check("R8 set pending", {31'b0, pending}, 32'd1);
    check("R8 no event", {31'b0, capEvent}, 32'd0);
    check("R8 value kept", capValue, 32'h0000_5555);
    swClr = 1'b1; step(); swClr = 1'b0;
    check("R6 sw clear", {31'b0, pending}, 32'd0);

    // R11 capture beats clear and read (pin high now)
    edgeFall = 1'b1; timeLow = 32'h0000_7777; capPin = 1'b0;
    step(); step();
    swClr = 1'b1; capRead = 1'b1;
    step();
    swClr = 1'b0; capRead = 1'b0;
    check("R11 event", {31'b0, capEvent}, 32'd1);
    check("R11 pending kept", {31'b0, pending}, 32'd1);
    check("R11 value", capValue, 32'h0000_7777);

    // R7 disarm coincident with capture (pin low now)
    edgeFall = 1'b0; timeLow = 32'h0012_3456; capPin = 1'b1;
    step(); step();
    disarm = 1'b1;
    step();
    disarm = 1'b0;
    check("R7 capture kept", {31'b0, capEvent}, 32'd1);
    check("R7 value", capValue, 32'h0012_3456 & 32'h001F_FFFF);
    check("R7 disarmed", {31'b0, armed}, 32'd0);
    armSet = 1'b1; disarm = 1'b1; step(); armSet = 1'b0; disarm = 1'b0;
    check("R7 disarm wins", {31'b0, armed}, 32'd0);

    // R3 unarmed edge ignored
    swClr = 1'b1; step(); swClr = 1'b0;
    timeLow = 32'h0000_0999; capPin = 1'b0; step(); step();
    capPin = 1'b1; step(); step(); step();
    check("R3 no event", {31'b0, capEvent}, 32'd0);
    check("R3 value kept", capValue, 32'h0012_3456 & 32'h001F_FFFF);
    check("R3 no pending", {31'b0, pending}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule